// File: doc/BRIEF.md
# Companding Serial Transmit Datapath

This block takes words from a host-side holding register and sends them out one bit at a time on a serial data line. A two-bit mode setting picks both the bit order and an optional logarithmic compression stage. In the two compressing modes, a 16-bit two's-complement sample becomes an 8-bit mu-law or A-law code word. The other two modes send data unchanged: either a word of programmable length sent most significant bit first, or the low byte sent least significant bit first.

The serial side runs on a bit-clock enable strobe. A frame-sync seen together with a bit-clock strobe starts a word. At that moment the holding register is formatted and compressed, then copied into the shift register. If the host has not supplied a new word, the previous word is sent again and an underrun strobe is raised. The host writes words through a ready/valid handshake. The handshake frees the holding register as soon as its contents have been moved into the shift register.

Top module: `compand_serial_tx`

## Requirements
- R1: After reset the mode is 00 (plain, MSB first) and the word length is 8. Both change only on a cycle with `cfgWe` high.
- R2: Mode 00 sends the low L bits of the host word, most significant first. L is the programmed length, clamped to the range 8 to 32.
- R3: Mode 01 sends bits 7:0 of the host word, bit 0 first.
- R4: Mode 10 encodes bits 15:2 as a 14-bit signed sample and ignores bits 1:0. It adds 33 to the magnitude, takes the segment from the leading one, keeps four mantissa bits, and sends the complement of {sign, segment, mantissa}. Sample 0 gives 0xFF and sample -1 gives 0x7E.
- R5: In mode 10, a biased magnitude above 8191 saturates. Positive full scale gives 0x80 and negative full scale gives 0x00.
- R6: Mode 11 encodes bits 15:3 as a 13-bit signed sample, with a positive sign bit of 1, and XORs the code with 0x55. Zero gives 0xD5, full scale gives 0xAA and 0x2A, and -1 gives 0x55.
- R7: Modes 01, 10 and 11 send exactly 8 bits, whatever length is programmed. `serOut` is 0 whenever no word is in flight.
- R8: A word starts on a clock edge where `fsync` and `bitClkEn` are both high. Bit 0 of the word appears on `serOut` in the following cycle. Each later `bitClkEn` edge advances one bit, and `serOut` holds steady between strobes.
- R9: `hostReady` is high while the holding register is empty. A word is taken on `hostValid && hostReady`. The register is freed on the word-start edge that moves it into the shift register.
- R10: If the holding register is empty at a word start, the previous word is sent again. `underrun` is then high for exactly the one cycle after that edge.
- R11: Formatting and compression use the mode in force at the word start, not the mode at the time the host wrote the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Mode value to write (00 plain, 01 LSB-first byte, 10 mu-law, 11 A-law) |
| cfgLen | input | 6 | Word length in bits to write; clamped to 8..32 |
| hostValid | input | 1 | Host offers a word |
| hostData | input | 32 | Host word (samples in bits 15:0) |
| hostReady | output | 1 | Holding register empty |
| bitClkEn | input | 1 | Bit-clock strobe |
| fsync | input | 1 | Frame-sync; starts a word together with bitClkEn |
| serOut | output | 1 | Serial data |
| underrun | output | 1 | One-cycle strobe: previous word resent |

## Verification
A wrong segment search or a wrong bias in an encoder shows up as a wrong 8-bit pattern on `serOut` within eight bit strobes of the word start. The chosen samples sit on segment edges, at both saturation limits, and on the discarded low bits, so each such fault changes at least one code. A bit counter loaded with the wrong length, or a companded word that uses the plain length, shows up as a non-zero bit after the eighth strobe. A lost or stuck holding-full flag shows up at once on `hostReady`, and at the next word start as a wrong word or a missing or extra `underrun` pulse.

// File: rtl/cst_pkg.sv
`timescale 1ns/1ps
package cst_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_LSB8  = 2'b01,
    MODE_MULAW = 2'b10,
    MODE_ALAW  = 2'b11
  } txMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;   // capture host word into holding register
    logic loadNew;  // format holding register into shifter
    logic loadOld;  // replay previous formatted word
    logic shift;    // advance one bit
  } txStrobe_t;
endpackage

// File: rtl/cst_encoder.sv
`timescale 1ns/1ps
// Logarithmic 8-bit encoder; IS_ALAW selects the law and the sample width.
module cst_encoder #(
  parameter bit IS_ALAW = 1'b0,
  localparam int LIN_W = IS_ALAW ? 13 : 14
) (
  input  logic [LIN_W-1:0] lin,
  output logic [7:0]       code
);
  generate
    if (IS_ALAW) begin : g_alaw
      logic [11:0] aMag;
      logic [2:0]  aSeg;
      logic [11:0] aShift;
      always_comb begin
        // negative: -x-1 equals the bitwise inverse
        aMag = lin[LIN_W-1] ? ~lin[11:0] : lin[11:0];
        aSeg = '0;
        for (int b = 5; b <= 11; b++) begin
          if (aMag[b]) aSeg = 3'(b - 4);
        end
        aShift = aMag >> ((aSeg <= 3'd1) ? 3'd1 : aSeg);
        code = {~lin[LIN_W-1], aSeg, aShift[3:0]} ^ 8'h55;
      end
    end else begin : g_mulaw
      logic [14:0] muMag;
      logic [14:0] muBias;
      logic [12:0] muPcm;
      logic [2:0]  muSeg;
      logic [12:0] muShift;
      always_comb begin
        muMag  = lin[LIN_W-1] ? (15'd0 - {lin[LIN_W-1], lin}) : {1'b0, lin};
        muBias = muMag + 15'd33;
        muPcm  = (muBias > 15'd8191) ? 13'h1FFF : muBias[12:0];
        muSeg  = '0;
        for (int b = 6; b <= 12; b++) begin
          if (muPcm[b]) muSeg = 3'(b - 5);
        end
        muShift = muPcm >> ({1'b0, muSeg} + 4'd1);
        code = ~{lin[LIN_W-1], muSeg, muShift[3:0]};
      end
    end
  endgenerate
endmodule

// File: rtl/cst_control.sv
`timescale 1ns/1ps
// Configuration, handshake and bit sequencing.
module cst_control
  import cst_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int MIN_LEN = 8,
  parameter int COMP_W  = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgMode,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             hostValid,
  output logic             hostReady,
  input  logic             bitClkEn,
  input  logic             fsync,
  output txStrobe_t        strb,
  output txMode_e          modeQ,
  output logic [LEN_W-1:0] effLen,
  output logic             wordActive,
  output logic             underrun
);
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] lenClamped;
  logic [LEN_W-1:0] bitsLeft;
  logic             holdFull;
  logic             wordStart;

  always_comb begin
    if (cfgLen < LEN_W'(MIN_LEN))      lenClamped = LEN_W'(MIN_LEN);
    else if (cfgLen > LEN_W'(MAX_LEN)) lenClamped = LEN_W'(MAX_LEN);
    else                               lenClamped = cfgLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_PLAIN;
      lenQ  <= LEN_W'(MIN_LEN);
    end else if (cfgWe) begin
      modeQ <= txMode_e'(cfgMode);
      lenQ  <= lenClamped;
    end
  end

  // companding and LSB-first byte modes override the programmed length
  assign effLen = (modeQ == MODE_PLAIN) ? lenQ : LEN_W'(COMP_W);

  assign wordStart    = fsync & bitClkEn;
  assign wordActive   = (bitsLeft != '0);
  assign hostReady    = ~holdFull;
  assign strb.accept  = hostValid & ~holdFull;
  assign strb.loadNew = wordStart & holdFull;
  assign strb.loadOld = wordStart & ~holdFull;
  assign strb.shift   = bitClkEn & ~fsync & wordActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      bitsLeft <= '0;
      underrun <= 1'b0;
    end else begin
      if (strb.loadNew)     holdFull <= 1'b0;
      else if (strb.accept) holdFull <= 1'b1;

      if (wordStart)       bitsLeft <= effLen;
      else if (strb.shift) bitsLeft <= bitsLeft - 1'b1;

      underrun <= strb.loadOld;
    end
  end
endmodule

// File: rtl/cst_datapath.sv
`timescale 1ns/1ps
// Holding register, formatter with compression, shift register.
module cst_datapath
  import cst_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int COMP_W  = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MAX_LEN-1:0] hostData,
  input  txStrobe_t          strb,
  input  txMode_e            modeQ,
  input  logic [LEN_W-1:0]   effLen,
  output logic               serBit
);
  logic [MAX_LEN-1:0] holdReg;
  logic [MAX_LEN-1:0] shReg;
  logic [MAX_LEN-1:0] lastWord;
  logic [MAX_LEN-1:0] fmtWord;
  logic [COMP_W-1:0]  revByte;
  logic [7:0]         lawCode [2];

  // index 0: mu-law on bits 15:2, index 1: A-law on bits 15:3
  generate
    for (genvar g = 0; g < 2; g++) begin : g_law
      localparam int LW = (g == 1) ? 13 : 14;
      cst_encoder #(.IS_ALAW(g == 1)) enc_i (
        .lin  (holdReg[15 -: LW]),
        .code (lawCode[g])
      );
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < COMP_W; i++) revByte[i] = holdReg[COMP_W-1-i];
  end

  always_comb begin
    unique case (modeQ)
      MODE_PLAIN: fmtWord = holdReg << (LEN_W'(MAX_LEN) - effLen);
      MODE_LSB8:  fmtWord = {revByte, {(MAX_LEN-COMP_W){1'b0}}};
      MODE_MULAW: fmtWord = {lawCode[0], {(MAX_LEN-8){1'b0}}};
      default:    fmtWord = {lawCode[1], {(MAX_LEN-8){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shReg    <= '0;
      lastWord <= '0;
    end else begin
      if (strb.accept) holdReg <= hostData;
      if (strb.loadNew) begin
        shReg    <= fmtWord;
        lastWord <= fmtWord;
      end else if (strb.loadOld) begin
        shReg <= lastWord;
      end else if (strb.shift) begin
        shReg <= shReg << 1;
      end
    end
  end

  assign serBit = shReg[MAX_LEN-1];
endmodule

// File: rtl/compand_serial_tx.sv
`timescale 1ns/1ps
module compand_serial_tx
  import cst_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int MIN_LEN = 8,
  parameter int COMP_W  = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgMode,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic               hostValid,
  input  logic [MAX_LEN-1:0] hostData,
  output logic               hostReady,
  input  logic               bitClkEn,
  input  logic               fsync,
  output logic               serOut,
  output logic               underrun
);
  txStrobe_t        strb;
  txMode_e          modeQ;
  logic [LEN_W-1:0] effLen;
  logic             wordActive;
  logic             serBit;

  cst_control #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .COMP_W(COMP_W)) ctl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgLen(cfgLen),
    .hostValid(hostValid), .hostReady(hostReady), .bitClkEn(bitClkEn),
    .fsync(fsync), .strb(strb), .modeQ(modeQ), .effLen(effLen),
    .wordActive(wordActive), .underrun(underrun)
  );

  cst_datapath #(.MAX_LEN(MAX_LEN), .COMP_W(COMP_W)) dp_i (
    .clk(clk), .rstN(rstN), .hostData(hostData), .strb(strb),
    .modeQ(modeQ), .effLen(effLen), .serBit(serBit)
  );

  assign serOut = wordActive & serBit;
endmodule

// File: rtl/cst_checker.sv
`timescale 1ns/1ps
module cst_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic       hostValid,
  input logic       hostReady,
  input logic       bitClkEn,
  input logic       fsync,
  input logic       serOut,
  input logic       underrun,
  input logic [1:0] modeQ
);
  logic [5:0] edgesSince;
  logic       loadedOnce;
  logic       wordComp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgesSince <= '0;
      loadedOnce <= 1'b0;
      wordComp   <= 1'b0;
    end else if (fsync && bitClkEn) begin
      edgesSince <= '0;
      loadedOnce <= 1'b1;
      wordComp   <= (modeQ != 2'b00);
    end else if (bitClkEn && edgesSince != 6'h3F) begin
      edgesSince <= edgesSince + 1'b1;
    end
  end

  // R1: mode register only moves on a configuration write
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(modeQ));

  // R7: an 8-bit word leaves the line at 0 after its eighth strobe
  assert_eight_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadedOnce && wordComp && edgesSince >= 6'd8) |-> !serOut);

  // R8: idle line before the first word
  assert_idle_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadedOnce |-> !serOut);

  // R8: line only moves on a bit strobe
  assert_line_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    !bitClkEn |=> $stable(serOut));

  // R9: an accepted word fills the holding register
  assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady) |=> !hostReady);

  // R10: underrun only follows a word start on an empty holding register
  assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(fsync && bitClkEn && hostReady));
endmodule

bind compand_serial_tx cst_checker chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .hostValid(hostValid),
  .hostReady(hostReady), .bitClkEn(bitClkEn), .fsync(fsync),
  .serOut(serOut), .underrun(underrun), .modeQ(modeQ)
);

// File: tb/compand_serial_tx_tb_top.sv
`timescale 1ns/1ps
module compand_serial_tx_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [1:0]  cfgMode;
  logic [5:0]  cfgLen;
  logic        hostValid;
  logic [31:0] hostData;
  logic        hostReady;
  logic        bitClkEn;
  logic        fsync;
  logic        serOut;
  logic        underrun;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  compand_serial_tx dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgLen(cfgLen),
    .hostValid(hostValid), .hostData(hostData), .hostReady(hostReady),
    .bitClkEn(bitClkEn), .fsync(fsync), .serOut(serOut), .underrun(underrun)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [5:0] len);
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = m; cfgLen = len;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    hostValid = 1'b1; hostData = d;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    hostValid = 1'b0;
  endtask

  // start a word and collect n bits, first bit first into the LSB end
  task automatic frame(input int n, output logic [31:0] bits,
                       output logic tail, output logic urun);
    @(negedge clk);
    fsync = 1'b1; bitClkEn = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    urun = underrun;
    bits = '0;
    for (int i = 0; i < n; i++) begin
      bits = {bits[30:0], serOut};
      @(negedge clk);
    end
    tail = serOut;
    bitClkEn = 1'b0;
  endtask

  task automatic sendCheck(input string req, input logic [31:0] d, input int n,
                           input logic [31:0] exp);
    logic [31:0] b; logic t; logic u;
    push(d);
    frame(n, b, t, u);
    check(req, b, exp);
    check({req, " idle after word"}, {31'd0, t}, 32'd0);
  endtask

  task automatic t_reset;
    check("R9 ready after reset", {31'd0, hostReady}, 32'd1);
    check("R8 line idle after reset", {31'd0, serOut}, 32'd0);
    check("R10 no underrun after reset", {31'd0, underrun}, 32'd0);
    // default mode plain MSB-first, length 8
    sendCheck("R1 default mode/length", 32'h0000_12F0, 8, 32'h0000_00F0);
  endtask

  task automatic t_plain;
    setCfg(2'b00, 6'd12);
    sendCheck("R2 length 12", 32'hFFFF_FABC, 12, 32'h0000_0ABC);
    setCfg(2'b00, 6'd32);
    sendCheck("R2 length 32", 32'hDEAD_BEEF, 32, 32'hDEAD_BEEF);
    setCfg(2'b00, 6'd5);
    sendCheck("R2 length clamp low", 32'h0000_01A5, 8, 32'h0000_00A5);
    setCfg(2'b00, 6'd40);
    sendCheck("R2 length clamp high", 32'h8000_0001, 32, 32'h8000_0001);
  endtask

  task automatic t_lsb;
    setCfg(2'b01, 6'd8);
    sendCheck("R3 LSB first", 32'h0000_FF2D, 8, 32'h0000_00B4);
    setCfg(2'b01, 6'd20);
    sendCheck("R7 LSB mode ignores length", 32'h0000_002D, 8, 32'h0000_00B4);
  endtask

  task automatic t_mulaw;
    setCfg(2'b10, 6'd16);
    sendCheck("R4 mu zero", 32'h0000_0000, 8, 32'h0000_00FF);
    sendCheck("R4 mu +1000", 32'h0000_0FA0, 8, 32'h0000_00AF);
    sendCheck("R4 mu low bits ignored", 32'h0000_0FA3, 8, 32'h0000_00AF);
    sendCheck("R4 mu -1000", 32'h0000_F060, 8, 32'h0000_002F);
    sendCheck("R4 mu -1", 32'h0000_FFFC, 8, 32'h0000_007E);
    sendCheck("R5 mu positive full scale", 32'h0000_7FFC, 8, 32'h0000_0080);
    sendCheck("R5 mu bias saturation", 32'h0000_7F80, 8, 32'h0000_0080);
    sendCheck("R5 mu negative full scale", 32'h0000_8000, 8, 32'h0000_0000);
  endtask

  task automatic t_alaw;
    setCfg(2'b11, 6'd24);
    sendCheck("R6 A zero", 32'h0000_0000, 8, 32'h0000_00D5);
    sendCheck("R6 A +1000", 32'h0000_1F40, 8, 32'h0000_008A);
    sendCheck("R6 A low bits ignored", 32'h0000_1F47, 8, 32'h0000_008A);
    sendCheck("R6 A -1", 32'h0000_FFF8, 8, 32'h0000_0055);
    sendCheck("R6 A positive full scale", 32'h0000_7FFF, 8, 32'h0000_00AA);
    sendCheck("R6 A negative full scale", 32'h0000_8000, 8, 32'h0000_002A);
  endtask

  task automatic t_transfer;
    logic [31:0] b; logic t; logic u;
    setCfg(2'b00, 6'd16);
    push(32'h0000_0FA0);
    setCfg(2'b10, 6'd16);
    frame(8, b, t, u);
    check("R11 mode at transfer governs", b, 32'h0000_00AF);
  endtask

  task automatic t_handshake;
    logic [31:0] b; logic t; logic u;
    setCfg(2'b00, 6'd8);
    push(32'h0000_0011);
    check("R9 ready low when full", {31'd0, hostReady}, 32'd0);
    @(negedge clk);
    hostValid = 1'b1; hostData = 32'h0000_0022;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 ready stays low while full", {31'd0, hostReady}, 32'd0);
    end
    hostValid = 1'b0;
    frame(8, b, t, u);
    check("R9 first word kept", b, 32'h0000_0011);
    check("R9 ready after transfer", {31'd0, hostReady}, 32'd1);
  endtask

  task automatic t_underrun;
    logic [31:0] b; logic t; logic u;
    setCfg(2'b00, 6'd8);
    push(32'h0000_005A);
    frame(8, b, t, u);
    check("R10 fresh word", b, 32'h0000_005A);
    check("R10 no underrun on fresh word", {31'd0, u}, 32'd0);
    frame(8, b, t, u);
    check("R10 previous word resent", b, 32'h0000_005A);
    check("R10 underrun strobe", {31'd0, u}, 32'd1);
    @(negedge clk);
    check("R10 underrun lasts one cycle", {31'd0, underrun}, 32'd0);
    push(32'h0000_003C);
    frame(8, b, t, u);
    check("R10 recovery word", b, 32'h0000_003C);
    check("R10 no underrun after refill", {31'd0, u}, 32'd0);
  endtask

  task automatic t_gap;
    logic [31:0] b;
    logic held;
    setCfg(2'b00, 6'd8);
    push(32'h0000_00C3);
    @(negedge clk);
    fsync = 1'b1; bitClkEn = 1'b1;
    @(negedge clk);
    fsync = 1'b0; bitClkEn = 1'b0;
    b = '0;
    held = 1'b1;
    for (int i = 0; i < 8; i++) begin
      b = {b[30:0], serOut};
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        if (serOut !== b[0]) held = 1'b0;
      end
      bitClkEn = 1'b1;
      @(negedge clk);
      bitClkEn = 1'b0;
    end
    check("R8 word with strobe gaps", b, 32'h0000_00C3);
    check("R8 line steady between strobes", {31'd0, held}, 32'd1);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    #(8 * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired got=running expected=done");
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgMode = 2'b00; cfgLen = 6'd8;
    hostValid = 1'b0; hostData = '0; bitClkEn = 1'b0; fsync = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_lsb();
    t_mulaw();
    t_alaw();
    t_transfer();
    t_handshake();
    t_underrun();
    t_gap();
    report();
    $finish;
  end
endmodule